// File: doc/BRIEF.md
# Banked Working Register File

This block holds the working registers of an 8051-style core: four banks of eight byte-wide registers that share the bottom of the low DATA space. A bank select picks the active bank. A register-number access to Rn then lands on DATA address 8·bank + n, the same cell that a direct access to that address reaches. Bank 0 is kept in flip-flops so that the common case never wakes the memory array. Banks 1 to 3 sit in a small synchronous two-port SRAM.

There are two access ports. The register-index port is addressed by the bank select and a 3-bit register number. The direct port is addressed by a 5-bit DATA address in the range 0x00–0x1F. Each port can read or write in every cycle. Each port has its own small decoder that steers the access to the flip-flop array or to the SRAM. It also records which store will answer the read, so that read data from either store comes back exactly one cycle later.

Each port's route register holds one of three named values: SRC_NONE (no read was issued), SRC_FLOP (the bank-0 flip-flops answer) and SRC_SRAM (the array answers). On each clock edge the value is loaded from the access presented in that cycle. A read below 0x08 moves it to SRC_FLOP, a read at 0x08 or above moves it to SRC_SRAM, and a write or an idle cycle moves it to SRC_NONE. Reset sets it to SRC_NONE.

Top module: `bank_rf`

## Requirements
- R1: After reset, all eight bank-0 registers read 0x00, both read-data outputs are 0x00 and both SRAM chip-enable bits are 0.
- R2: A register-index access with bank select b and register number n reaches DATA address 8·b + n. A value written through one port reads back through the other port at that address.
- R3: A direct-port address a (0x00–0x1F) selects bank a[4:3], register a[2:0]. All 32 addresses hold independent values.
- R4: Bit 0 of `sram_ce` belongs to the register-index port and bit 1 to the direct port. A bit is 0 in every cycle in which its port is idle or accesses 0x00–0x07. It is 1 in every cycle in which its port accesses 0x08–0x1F.
- R5: Read data appears on the port's read-data output in the cycle after the read is presented, for both storage types, and not in the cycle the read is presented.
- R6: When one port reads an address that the other port writes in the same cycle, the read returns the old value. The new value is visible from the next access on.
- R7: When both ports write the same address in the same cycle, the direct port's value is stored.
- R8: A port's read-data output is 0x00 in the cycle after a cycle in which that port issued no read (idle or write).
- R9: Writing register n of one bank leaves register n of every other bank unchanged.
- R10: Changing only the bank select makes the register-index port read the same register number from a different bank, and no stored data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Active bank for the register-index port |
| ri_en | input | 1 | Register-index port access valid |
| ri_we | input | 1 | Register-index port write (1) or read (0) |
| ri_idx | input | 3 | Register number R0–R7 |
| ri_wdata | input | 8 | Register-index port write data |
| ri_rdata | output | 8 | Register-index port read data, one cycle after the read |
| da_en | input | 1 | Direct port access valid |
| da_we | input | 1 | Direct port write (1) or read (0) |
| da_addr | input | 5 | Direct DATA address 0x00–0x1F |
| da_wdata | input | 8 | Direct port write data |
| da_rdata | output | 8 | Direct port read data, one cycle after the read |
| sram_ce | output | 2 | SRAM chip enable per port (bit 0 index port, bit 1 direct port) |

## Verification
The address map is tested with two complementary fills. In the first, all 32 cells are written through the direct port with address-dependent values and read back through the register-index port in every bank. In the second, the cells are written through the register-index port with inverted values and read back directly. A swapped bank field, an off-by-one SRAM offset or a bank-0 leak into the array gives a mismatch in at least one of these fills. Back-to-back reads that alternate between flip-flop and SRAM addresses separate a latency mismatch between the two stores. Same-cycle read/write and write/write collisions, placed once in bank 0 and once in an SRAM bank, tell the old-value policy and the direct-port priority apart in both storage types. The chip-enable check runs on every access and separates correct steering from a store that is merely enabled too often.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

    // Which store answers the read issued in the previous cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FLOP = 2'd1,
        SRC_SRAM = 2'd2
    } rd_src_e;

endpackage

// File: rtl/bank_rf_route.sv
module bank_rf_route
    import bank_rf_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int FLOP_WORDS = 8,
    parameter int SRAM_AW    = 5
) (
    input  logic               en,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    output logic               flop_rd,
    output logic               flop_wr,
    output logic               sram_ce,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output rd_src_e            next_src
);

    logic              is_flop;
    logic [ADDR_W-1:0] sram_off;

    always_comb begin
        is_flop   = (addr < ADDR_W'(FLOP_WORDS));
        sram_off  = addr - ADDR_W'(FLOP_WORDS);
        sram_addr = sram_off[SRAM_AW-1:0];
        flop_wr   = en &  we &  is_flop;
        flop_rd   = en & ~we &  is_flop;
        sram_ce   = en & ~is_flop;
        sram_we   = we;
        unique case ({en, we})
            2'b10:   next_src = is_flop ? SRC_FLOP : SRC_SRAM;
            default: next_src = SRC_NONE;
        endcase
    end

endmodule

// File: rtl/bank_rf_flops.sv
module bank_rf_flops #(
    parameter int DATA_W = 8,
    parameter int WORDS  = 8,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [AW-1:0]     b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    logic [DATA_W-1:0] cells [WORDS];

    // Port b is written last, so it wins a same-address write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else begin
            if (a_wr) cells[a_addr] <= a_wdata;
            if (b_wr) cells[b_addr] <= b_wdata;
        end
    end

    // Registered read gives the same latency as the SRAM
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_rd) a_rdata <= cells[a_addr];
            if (b_rd) b_rdata <= cells[b_addr];
        end
    end

endmodule

// File: rtl/bank_rf_sram.sv
module bank_rf_sram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 24,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              a_ce,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_ce,
    input  logic              b_we,
    input  logic [AW-1:0]     b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_ce &&  a_we) mem[a_addr] <= a_wdata;
        if (b_ce &&  b_we) mem[b_addr] <= b_wdata;
        if (a_ce && !a_we) a_rdata     <= mem[a_addr];
        if (b_ce && !b_we) b_rdata     <= mem[b_addr];
    end

endmodule

// File: rtl/bank_rf.sv
module bank_rf
    import bank_rf_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int DATA_W        = 8,
    parameter int FLOP_BANKS    = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(NUM_BANKS)-1:0]     bank_sel,
    input  logic                             ri_en,
    input  logic                             ri_we,
    input  logic [$clog2(REGS_PER_BANK)-1:0] ri_idx,
    input  logic [DATA_W-1:0]                ri_wdata,
    output logic [DATA_W-1:0]                ri_rdata,
    input  logic                             da_en,
    input  logic                             da_we,
    input  logic [$clog2(NUM_BANKS)+$clog2(REGS_PER_BANK)-1:0] da_addr,
    input  logic [DATA_W-1:0]                da_wdata,
    output logic [DATA_W-1:0]                da_rdata,
    output logic [1:0]                       sram_ce
);

    localparam int IDX_W      = $clog2(REGS_PER_BANK);
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int ADDR_W     = IDX_W + BANK_W;
    localparam int FLOP_WORDS = FLOP_BANKS * REGS_PER_BANK;
    localparam int SRAM_DEPTH = (NUM_BANKS - FLOP_BANKS) * REGS_PER_BANK;
    localparam int FLOP_AW    = $clog2(FLOP_WORDS);
    localparam int SRAM_AW    = $clog2(SRAM_DEPTH);
    localparam int NPORT      = 2;   // 0: register-index, 1: direct

    logic [NPORT-1:0]  p_en, p_we, f_rd, f_wr, s_ce, s_we;
    logic [ADDR_W-1:0] p_addr  [NPORT];
    logic [DATA_W-1:0] p_wdata [NPORT];
    logic [DATA_W-1:0] flop_q  [NPORT];
    logic [DATA_W-1:0] sram_q  [NPORT];
    logic [DATA_W-1:0] rd_mux  [NPORT];
    logic [SRAM_AW-1:0] s_addr [NPORT];
    rd_src_e           nxt_src [NPORT];
    rd_src_e           src_q   [NPORT];

    assign p_en[0]    = ri_en;
    assign p_we[0]    = ri_we;
    assign p_addr[0]  = {bank_sel, ri_idx};
    assign p_wdata[0] = ri_wdata;
    assign p_en[1]    = da_en;
    assign p_we[1]    = da_we;
    assign p_addr[1]  = da_addr;
    assign p_wdata[1] = da_wdata;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        bank_rf_route #(
            .ADDR_W     (ADDR_W),
            .FLOP_WORDS (FLOP_WORDS),
            .SRAM_AW    (SRAM_AW)
        ) u_route (
            .en        (p_en[p]),
            .we        (p_we[p]),
            .addr      (p_addr[p]),
            .flop_rd   (f_rd[p]),
            .flop_wr   (f_wr[p]),
            .sram_ce   (s_ce[p]),
            .sram_we   (s_we[p]),
            .sram_addr (s_addr[p]),
            .next_src  (nxt_src[p])
        );

        // Route register: remembers which store answers next cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) src_q[p] <= SRC_NONE;
            else        src_q[p] <= nxt_src[p];
        end

        always_comb begin
            unique case (src_q[p])
                SRC_FLOP: rd_mux[p] = flop_q[p];
                SRC_SRAM: rd_mux[p] = sram_q[p];
                default:  rd_mux[p] = '0;
            endcase
        end
    end

    bank_rf_flops #(
        .DATA_W (DATA_W),
        .WORDS  (FLOP_WORDS),
        .AW     (FLOP_AW)
    ) u_flops (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_wr    (f_wr[0]),
        .a_rd    (f_rd[0]),
        .a_addr  (p_addr[0][FLOP_AW-1:0]),
        .a_wdata (p_wdata[0]),
        .a_rdata (flop_q[0]),
        .b_wr    (f_wr[1]),
        .b_rd    (f_rd[1]),
        .b_addr  (p_addr[1][FLOP_AW-1:0]),
        .b_wdata (p_wdata[1]),
        .b_rdata (flop_q[1])
    );

    bank_rf_sram #(
        .DATA_W (DATA_W),
        .DEPTH  (SRAM_DEPTH),
        .AW     (SRAM_AW)
    ) u_sram (
        .clk     (clk),
        .a_ce    (s_ce[0]),
        .a_we    (s_we[0]),
        .a_addr  (s_addr[0]),
        .a_wdata (p_wdata[0]),
        .a_rdata (sram_q[0]),
        .b_ce    (s_ce[1]),
        .b_we    (s_we[1]),
        .b_addr  (s_addr[1]),
        .b_wdata (p_wdata[1]),
        .b_rdata (sram_q[1])
    );

    assign ri_rdata = rd_mux[0];
    assign da_rdata = rd_mux[1];
    assign sram_ce  = s_ce;

endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk #(
    parameter int IDX_W      = 3,
    parameter int BANK_W     = 2,
    parameter int DATA_W     = 8,
    parameter int FLOP_WORDS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [BANK_W-1:0]       bank_sel,
    input logic                    ri_en,
    input logic                    ri_we,
    input logic [IDX_W-1:0]        ri_idx,
    input logic [DATA_W-1:0]       ri_rdata,
    input logic                    da_en,
    input logic                    da_we,
    input logic [IDX_W+BANK_W-1:0] da_addr,
    input logic [DATA_W-1:0]       da_rdata,
    input logic [1:0]              sram_ce
);

    localparam int AW = IDX_W + BANK_W;

    AST_RI_LOW_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_en && ({bank_sel, ri_idx} < AW'(FLOP_WORDS))) |-> !sram_ce[0]); // R4
    AST_DA_LOW_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (da_en && (da_addr < AW'(FLOP_WORDS))) |-> !sram_ce[1]); // R4
    AST_DA_HIGH_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (da_en && (da_addr >= AW'(FLOP_WORDS))) |-> sram_ce[1]); // R4
    AST_IDLE_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ri_en && !da_en) |-> (sram_ce == 2'b00)); // R4
    AST_RI_NOREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(ri_en && !ri_we) |=> (ri_rdata == '0)); // R8
    AST_DA_NOREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(da_en && !da_we) |=> (da_rdata == '0)); // R8
    AST_SAME_ADDR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_en && !ri_we && da_en && !da_we && ({bank_sel, ri_idx} == da_addr))
        |=> (ri_rdata == da_rdata)); // R2

endmodule

bind bank_rf bank_rf_chk #(
    .IDX_W      (IDX_W),
    .BANK_W     (BANK_W),
    .DATA_W     (DATA_W),
    .FLOP_WORDS (FLOP_WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_sel (bank_sel),
    .ri_en    (ri_en),
    .ri_we    (ri_we),
    .ri_idx   (ri_idx),
    .ri_rdata (ri_rdata),
    .da_en    (da_en),
    .da_we    (da_we),
    .da_addr  (da_addr),
    .da_rdata (da_rdata),
    .sram_ce  (sram_ce)
);

// File: tb/bank_rf_test.sv
module bank_rf_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bank_sel;
    logic       ri_en, ri_we, da_en, da_we;
    logic [2:0] ri_idx;
    logic [4:0] da_addr;
    logic [7:0] ri_wdata, da_wdata, ri_rdata, da_rdata;
    logic [1:0] sram_ce;

    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;
    logic [7:0] model [32];

    always #5 clk = ~clk;

    bank_rf uut (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .ri_en(ri_en), .ri_we(ri_we), .ri_idx(ri_idx),
        .ri_wdata(ri_wdata), .ri_rdata(ri_rdata),
        .da_en(da_en), .da_we(da_we), .da_addr(da_addr),
        .da_wdata(da_wdata), .da_rdata(da_rdata), .sram_ce(sram_ce)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ri_en = 1'b0; ri_we = 1'b0; da_en = 1'b0; da_we = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 5) & 8'hff);
    endfunction

    task automatic da_write(logic [4:0] a, logic [7:0] d);
        da_en = 1'b1; da_we = 1'b1; da_addr = a; da_wdata = d;
        #1 check("R4 direct write chip enable", 32'(sram_ce[1]), 32'(a >= 5'd8));
        step();
        model[a] = d;
        idle();
    endtask

    task automatic da_read(logic [4:0] a, logic [7:0] exp, string tag);
        da_en = 1'b1; da_we = 1'b0; da_addr = a;
        #1 check("R4 direct read chip enable", 32'(sram_ce[1]), 32'(a >= 5'd8));
        step();
        check(tag, 32'(da_rdata), 32'(exp));
        idle();
    endtask

    task automatic ri_write(logic [1:0] b, logic [2:0] n, logic [7:0] d);
        bank_sel = b; ri_en = 1'b1; ri_we = 1'b1; ri_idx = n; ri_wdata = d;
        #1 check("R4 index write chip enable", 32'(sram_ce[0]), 32'(b != 2'd0));
        step();
        model[{b, n}] = d;
        idle();
    endtask

    task automatic ri_read(logic [1:0] b, logic [2:0] n, logic [7:0] exp, string tag);
        bank_sel = b; ri_en = 1'b1; ri_we = 1'b0; ri_idx = n;
        #1 check("R4 index read chip enable", 32'(sram_ce[0]), 32'(b != 2'd0));
        step();
        check(tag, 32'(ri_rdata), 32'(exp));
        idle();
    endtask

    task automatic t_reset();
        check("R1 index rdata after reset", 32'(ri_rdata), 0);
        check("R1 direct rdata after reset", 32'(da_rdata), 0);
        check("R1 chip enables after reset", 32'(sram_ce), 0);
        for (int a = 0; a < 8; a++) da_read(5'(a), 8'h00, "R1 bank0 cleared");
    endtask

    task automatic t_direct_fill();
        for (int a = 0; a < 32; a++) da_write(5'(a), pat(a));
        for (int b = 0; b < 4; b++)
            for (int n = 0; n < 8; n++)
                ri_read(2'(b), 3'(n), model[b*8+n], "R3 direct fill read by index");
    endtask

    task automatic t_index_fill();
        for (int b = 0; b < 4; b++)
            for (int n = 0; n < 8; n++)
                ri_write(2'(b), 3'(n), ~pat(b*8+n));
        for (int a = 0; a < 32; a++) da_read(5'(a), model[a], "R2 index fill read direct");
        // R9: one bank's write must not touch the same register in others
        ri_write(2'd2, 3'd5, 8'hA7);
        for (int b = 0; b < 4; b++)
            da_read(5'(b*8+5), model[b*8+5], "R9 bank isolation");
    endtask

    task automatic t_latency();
        da_en = 1'b1; da_we = 1'b0; da_addr = 5'd2;
        step();
        check("R5 flop read next cycle", 32'(da_rdata), 32'(model[2]));
        da_addr = 5'h15;
        #1 check("R5 sram data not same cycle", 32'(da_rdata), 32'(model[2]));
        step();
        check("R5 sram read next cycle", 32'(da_rdata), 32'(model[5'h15]));
        da_addr = 5'h03;
        step();
        check("R5 flop after sram", 32'(da_rdata), 32'(model[3]));
        idle();
        step();
        check("R8 idle gives zero", 32'(da_rdata), 0);
        da_write(5'h09, 8'h3C);
        check("R8 write gives zero", 32'(da_rdata), 0);
    endtask

    task automatic t_collide(logic [4:0] a, logic [7:0] nv);
        logic [7:0] old;
        old = model[a];
        bank_sel = a[4:3]; ri_en = 1'b1; ri_we = 1'b0; ri_idx = a[2:0];
        da_en = 1'b1; da_we = 1'b1; da_addr = a; da_wdata = nv;
        step();
        check("R6 read during write returns old", 32'(ri_rdata), 32'(old));
        model[a] = nv;
        idle();
        ri_read(a[4:3], a[2:0], nv, "R6 new value after collision");
    endtask

    task automatic t_dual_write(logic [4:0] a, logic [7:0] vi, logic [7:0] vd);
        bank_sel = a[4:3]; ri_en = 1'b1; ri_we = 1'b1; ri_idx = a[2:0]; ri_wdata = vi;
        da_en = 1'b1; da_we = 1'b1; da_addr = a; da_wdata = vd;
        step();
        model[a] = vd;
        idle();
        da_read(a, vd, "R7 direct port wins");
        ri_read(a[4:3], a[2:0], vd, "R7 direct port wins via index");
    endtask

    task automatic t_bank_switch();
        for (int b = 3; b >= 0; b--)
            ri_read(2'(b), 3'd6, model[b*8+6], "R10 bank select switch");
        for (int b = 0; b < 4; b++)
            ri_read(2'(b), 3'd6, model[b*8+6], "R10 data kept after switching");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1-all actual=timeout expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bank_sel = 2'd0; ri_idx = '0; da_addr = '0;
        ri_wdata = '0; da_wdata = '0;
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_direct_fill();
        t_index_fill();
        t_latency();
        t_collide(5'h03, 8'h5A);
        t_collide(5'h12, 8'hC3);
        t_dual_write(5'h05, 8'h11, 8'h22);
        t_dual_write(5'h1E, 8'h33, 8'h44);
        t_bank_switch();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule